// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block collects a set of level-sensitive interrupt sources and presents them to a processor on two request lines. One is a normal interrupt request and the other is a fast interrupt request. Each line has its own enable mask. Software never writes a mask directly: it ORs bits in through one register index and removes them through another. A line is driven high whenever at least one raw source is high and enabled for that line.

Source 0 has an extra software path. A latch inside the block can be raised and lowered through a pair of register indices, and raw bit 0 is the OR of that latch with input line 0. Software reaches the block through a simple word-indexed register bus. Writes take effect on the clock edge. Reads are combinational and return masked status, raw status or the masks themselves. Both request lines are registered, so each one shows the state as it stands after the most recent clock edge.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A synchronous reset, with rst_n low at a clock edge, clears both masks and the software latch. irq_o and fiq_o are low after that edge.
- R2: A write to index 2 ORs bus_wdata into the normal-request mask. A write to index 3 clears every mask bit that is 1 in bus_wdata. A read of index 2 returns the mask.
- R3: A write to index 10 ORs bus_wdata into the fast-request mask. A write to index 11 clears every mask bit that is 1 in bus_wdata. A read of index 10 returns the mask.
- R4: Raw bit 0 is src_i[0] OR the software latch. A write to index 4 with data bit 0 set raises the latch, and a write to index 5 with data bit 0 set lowers it. Either write with data bit 0 clear, and all other data bits, leave the latch unchanged.
- R5: A read of index 1 or index 9 returns the raw level, which is src_i with bit 0 merged with the latch. A read of index 4 returns raw bit 0 in bit 0, with all other bits zero.
- R6: A read of index 0 returns the raw level ANDed with the normal mask. A read of index 8 returns the raw level ANDed with the fast mask.
- R7: After every clock edge out of reset, irq_o equals the OR-reduction of (raw level sampled at that edge AND normal mask after that edge).
- R8: After every clock edge out of reset, fiq_o equals the OR-reduction of (raw level sampled at that edge AND fast mask after that edge).
- R9: Writes to indices 0, 1, 8, 9 and to any index not named above change no state. Reads of indices 3, 5, 11 and of any index not named above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_we | input | 1 | Write strobe for the addressed index |
| bus_idx | input | 4 | Word index of the register access |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Combinational read data for bus_idx |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench builds the block with its default NUM_SRC of 32, which is the full bus width. At that width every mask bit, the merge of the software latch into bit 0, and the top source bit can be reached through the register bus. Random write data and sparse random source patterns exercise the set/clear masks and both request lines across all 32 positions. The sweep over all 16 word indices shows the ignored writes and the zero reads.

// File: rtl/irqc_pkg.sv
// Package: shared register index map and channel constants for the
// dual-output interrupt controller. The index values are the software
// contract and must not be renumbered.
package irqc_pkg;

    typedef logic [3:0] reg_idx_t;

    localparam int CH_NUM = 2;   // channel 0 = normal request, 1 = fast request

    localparam reg_idx_t IDX_IRQ_STAT   = 4'd0;
    localparam reg_idx_t IDX_RAW_A      = 4'd1;
    localparam reg_idx_t IDX_IRQ_EN_SET = 4'd2;
    localparam reg_idx_t IDX_IRQ_EN_CLR = 4'd3;
    localparam reg_idx_t IDX_SOFT_SET   = 4'd4;
    localparam reg_idx_t IDX_SOFT_CLR   = 4'd5;
    localparam reg_idx_t IDX_FIQ_STAT   = 4'd8;
    localparam reg_idx_t IDX_RAW_B      = 4'd9;
    localparam reg_idx_t IDX_FIQ_EN_SET = 4'd10;
    localparam reg_idx_t IDX_FIQ_EN_CLR = 4'd11;

    localparam reg_idx_t SET_IDX [CH_NUM] = '{IDX_IRQ_EN_SET, IDX_FIQ_EN_SET};
    localparam reg_idx_t CLR_IDX [CH_NUM] = '{IDX_IRQ_EN_CLR, IDX_FIQ_EN_CLR};

endpackage

// File: rtl/irqc_en_bank.sv
// Module: enable mask with separate set and clear strobes.
// Assumes at most one strobe per cycle (one bus index per access).
// Exposes both the stored mask and its next value, so a downstream
// register can act on the same edge as the mask update.
module irqc_en_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] mask_d
);

    // Next mask: OR in on set, knock out on clear.
    always_comb begin
        mask_d = mask_q;
        if (set_stb) mask_d = mask_d | wdata;
        if (clr_stb) mask_d = mask_d & ~wdata;
    end

    // Store the mask; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

endmodule

// File: rtl/irqc_soft_latch.sv
// Module: software interrupt latch for source 0.
// Set and clear act only when the qualifying data bit is 1.
module irqc_soft_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stb,
    input  logic clr_stb,
    input  logic wbit,
    output logic soft_q,
    output logic soft_d
);

    // Next latch value from the qualified strobes.
    always_comb begin
        soft_d = soft_q;
        if (set_stb && wbit) soft_d = 1'b1;
        if (clr_stb && wbit) soft_d = 1'b0;
    end

    // Hold the latch; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= soft_d;
    end

endmodule

// File: rtl/irqc_req_reg.sv
// Module: registered request line. Asserts when any raw bit is
// enabled. Takes next-state raw and mask so that the line reflects
// the state after the same edge. Sources are assumed synchronous to clk.
module irqc_req_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_d,
    input  logic [W-1:0] mask_d,
    output logic         req_q
);

    // Register the OR-reduction of enabled raw bits.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |(raw_d & mask_d);
    end

endmodule

// File: rtl/dual_irq_ctrl.sv
// Module: dual-output level-sensitive interrupt controller.
// Two enable masks (normal/fast), each changed through set and clear
// indices; a software latch merged into raw bit 0; combinational reads
// of masked status, raw status and masks; registered request outputs.
// Assumes src_i is synchronous to clk.
module dual_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_we,
    input  logic [3:0]         bus_idx,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    logic [NUM_SRC-1:0] en_q [CH_NUM];
    logic [NUM_SRC-1:0] en_d [CH_NUM];
    logic [CH_NUM-1:0]  req_q;
    logic               soft_q;
    logic               soft_d;
    logic [NUM_SRC-1:0] raw_now;
    logic [NUM_SRC-1:0] raw_next;
    logic [NUM_SRC-1:0] irq_en_q;
    logic [NUM_SRC-1:0] fiq_en_q;

    // One mask bank and one request register per output channel.
    for (genvar k = 0; k < CH_NUM; k++) begin : g_ch
        irqc_en_bank #(.W(NUM_SRC)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (bus_we && (bus_idx == SET_IDX[k])),
            .clr_stb (bus_we && (bus_idx == CLR_IDX[k])),
            .wdata   (bus_wdata),
            .mask_q  (en_q[k]),
            .mask_d  (en_d[k])
        );

        irqc_req_reg #(.W(NUM_SRC)) u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_d  (raw_next),
            .mask_d (en_d[k]),
            .req_q  (req_q[k])
        );
    end

    irqc_soft_latch u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_we && (bus_idx == IDX_SOFT_SET)),
        .clr_stb (bus_we && (bus_idx == IDX_SOFT_CLR)),
        .wbit    (bus_wdata[0]),
        .soft_q  (soft_q),
        .soft_d  (soft_d)
    );

    // Raw level now (for reads) and after the edge (for requests).
    always_comb begin
        raw_now  = src_i | NUM_SRC'(soft_q);
        raw_next = src_i | NUM_SRC'(soft_d);
    end

    // Read multiplexer; write-only and unmapped indices read zero.
    always_comb begin
        case (bus_idx)
            IDX_IRQ_STAT:   bus_rdata = raw_now & en_q[0];
            IDX_RAW_A:      bus_rdata = raw_now;
            IDX_IRQ_EN_SET: bus_rdata = en_q[0];
            IDX_SOFT_SET:   bus_rdata = NUM_SRC'(raw_now[0]);
            IDX_FIQ_STAT:   bus_rdata = raw_now & en_q[1];
            IDX_RAW_B:      bus_rdata = raw_now;
            IDX_FIQ_EN_SET: bus_rdata = en_q[1];
            default:        bus_rdata = '0;
        endcase
    end

    // Name the channel views for the outputs and the bound checker.
    always_comb begin
        irq_en_q = en_q[0];
        fiq_en_q = en_q[1];
        irq_o    = req_q[0];
        fiq_o    = req_q[1];
    end

endmodule

// File: rtl/irqc_checker.sv
// Module: temporal checks for dual_irq_ctrl, attached by bind.
// Observes ports plus the stored masks and software latch.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bus_we,
    input logic [3:0]         bus_idx,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] irq_en,
    input logic [NUM_SRC-1:0] fiq_en,
    input logic               soft_q
);

    // R1: a reset edge leaves both requests low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o && irq_en == '0 && fiq_en == '0 && !soft_q));

    // R2: set and clear of the normal mask.
    p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_IRQ_EN_SET) |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata)));
    p_irq_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_IRQ_EN_CLR) |=> ((irq_en & $past(bus_wdata)) == '0));

    // R3: set and clear of the fast mask.
    p_fiq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_FIQ_EN_SET) |=> ((fiq_en & $past(bus_wdata)) == $past(bus_wdata)));
    p_fiq_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_FIQ_EN_CLR) |=> ((fiq_en & $past(bus_wdata)) == '0));

    // R4: software latch set and clear.
    p_soft_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_SOFT_SET && bus_wdata[0]) |=> soft_q);
    p_soft_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_SOFT_CLR && bus_wdata[0]) |=> !soft_q);

    // R7 / R8: request lines track enabled raw bits after each edge.
    p_irq_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == (|(($past(src_i) | NUM_SRC'(soft_q)) & irq_en))));
    p_fiq_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == (|(($past(src_i) | NUM_SRC'(soft_q)) & fiq_en))));

    // R9: writes to status indices leave all state untouched.
    p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_idx == IDX_IRQ_STAT || bus_idx == IDX_RAW_A ||
                    bus_idx == IDX_FIQ_STAT || bus_idx == IDX_RAW_B))
        |=> ($stable(irq_en) && $stable(fiq_en) && $stable(soft_q)));

endmodule

bind dual_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .irq_en    (irq_en_q),
    .fiq_en    (fiq_en_q),
    .soft_q    (soft_q)
);

// File: tb/sim_dual_irq_ctrl.sv
// Bench: directed corner cases followed by seeded random traffic,
// checked against a register-level model kept in bench variables.
module sim_dual_irq_ctrl;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_idx = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq_o;
    logic         fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state
    logic [N-1:0] m_irq = '0;
    logic [N-1:0] m_fiq = '0;
    logic         m_soft = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_irq_ctrl #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [N-1:0] f_raw(logic [N-1:0] s, logic sf);
        return s | {{(N-1){1'b0}}, sf};
    endfunction

    function automatic logic [N-1:0] f_read(logic [3:0] idx, logic [N-1:0] s);
        logic [N-1:0] r;
        r = f_raw(s, m_soft);
        case (idx)
            4'd0:  return r & m_irq;
            4'd1:  return r;
            4'd2:  return m_irq;
            4'd4:  return {{(N-1){1'b0}}, r[0]};
            4'd8:  return r & m_fiq;
            4'd9:  return r;
            4'd10: return m_fiq;
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: check requests, drive, check read, take the edge.
    task automatic cyc(logic we, logic [3:0] idx, logic [N-1:0] d, logic [N-1:0] s);
        @(negedge clk);
        chk("R7 irq_o", {{(N-1){1'b0}}, irq_o},
            {{(N-1){1'b0}}, |(f_raw(src_i, m_soft) & m_irq)});
        chk("R8 fiq_o", {{(N-1){1'b0}}, fiq_o},
            {{(N-1){1'b0}}, |(f_raw(src_i, m_soft) & m_fiq)});
        bus_we = we; bus_idx = idx; bus_wdata = d; src_i = s;
        #1;
        if (!we) begin
            case (idx)
                4'd2, 4'd3:   chk("R2 read", bus_rdata, f_read(idx, s));
                4'd10, 4'd11: chk("R3 read", bus_rdata, f_read(idx, s));
                4'd1, 4'd4, 4'd9: chk("R5 read", bus_rdata, f_read(idx, s));
                4'd0, 4'd8:   chk("R6 read", bus_rdata, f_read(idx, s));
                default:      chk("R9 read", bus_rdata, f_read(idx, s));
            endcase
        end
        @(posedge clk);
        if (we) begin
            case (idx)
                4'd2:  m_irq = m_irq | d;
                4'd3:  m_irq = m_irq & ~d;
                4'd4:  if (d[0]) m_soft = 1'b1;
                4'd5:  if (d[0]) m_soft = 1'b0;
                4'd10: m_fiq = m_fiq | d;
                4'd11: m_fiq = m_fiq & ~d;
                default: ;
            endcase
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5813));
        src_i = 32'hFFFF_FFFF;
        bus_we = 1'b1; bus_idx = 4'd2; bus_wdata = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset cleared both lines, masks and latch
        chk("R1 irq_o", {31'b0, irq_o}, '0);
        chk("R1 fiq_o", {31'b0, fiq_o}, '0);
        bus_we = 1'b0; bus_idx = 4'd2; #1;
        chk("R1 irq mask", bus_rdata, '0);
        bus_idx = 4'd10; #1;
        chk("R1 fiq mask", bus_rdata, '0);
        src_i = '0; bus_idx = 4'd4; #1;
        chk("R1 soft latch", bus_rdata, '0);
        rst_n = 1'b1;

        // R2: set then clear of the normal mask
        cyc(1, 4'd2, 32'hF0F0_0001, '0);
        cyc(1, 4'd2, 32'h0000_8000, '0);
        cyc(0, 4'd2, '0, '0);
        cyc(1, 4'd3, 32'h3000_0001, '0);
        cyc(0, 4'd2, '0, 32'h0000_8000);
        // R3: set then clear of the fast mask
        cyc(1, 4'd10, 32'h8000_0003, '0);
        cyc(1, 4'd11, 32'h0000_0002, 32'h8000_0000);
        cyc(0, 4'd10, '0, 32'h8000_0000);
        // R4: software latch via bit 0 only
        cyc(1, 4'd4, 32'hFFFF_FFFE, '0);
        cyc(0, 4'd4, '0, '0);
        cyc(1, 4'd4, 32'h0000_0001, '0);
        cyc(0, 4'd4, '0, '0);
        cyc(1, 4'd5, 32'hFFFF_FFFE, '0);
        cyc(0, 4'd1, '0, 32'h0000_0100);
        cyc(1, 4'd5, 32'h0000_0001, '0);
        // R5: index 4 hides the other raw bits
        cyc(0, 4'd4, '0, 32'hFFFF_FFFE);
        cyc(0, 4'd4, '0, 32'h0000_0001);
        // R6: masked status
        cyc(0, 4'd0, '0, 32'hFFFF_FFFF);
        cyc(0, 4'd8, '0, 32'hFFFF_FFFF);
        // R9: writes to status and unmapped indices are ignored
        foreach (bus_rdata[i]) begin end
        for (int j = 0; j < 16; j++) begin
            if (!(j inside {2, 3, 4, 5, 10, 11})) begin
                cyc(1, 4'(j), 32'hFFFF_FFFF, '0);
                cyc(0, 4'd2, '0, '0);
                cyc(0, 4'd10, '0, '0);
                cyc(0, 4'd4, '0, '0);
            end
        end
        for (int j = 0; j < 16; j++) cyc(0, 4'(j), '0, 32'hA5A5_5A5B);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [3:0]   ri;
            logic [N-1:0] rd, rs;
            ri = 4'($urandom % 16);
            rd = $urandom;
            if ($urandom % 3 == 0) rd = rd & $urandom & $urandom;
            rs = $urandom & $urandom & $urandom & $urandom;
            if ($urandom % 4 == 0) rs = '0;
            cyc(($urandom % 2) == 1, ri, rd, rs);
        end
        cyc(0, 4'd0, '0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule